// File: doc/BRIEF.md
# Prioritized Pin-Function Multiplexing Port

This block is an 8-bit general purpose I/O port. Six of its pins are shared with peripheral functions: a serial peripheral interface (four lines), a two-wire IIC bus (data and clock), four PWM channels and a CAN controller (transmit and receive). Software reaches the port over a small register bus. The bus has two locations: a data register at address 0 and a direction register at address 1. Bits 1 and 0 are always plain GPIO.

Each shared pin has its own fixed priority chain. The chain covers only the peripherals wired to that pin. The highest-priority enabled peripheral supplies the pin's output value and output enable. When none of them is enabled, the GPIO registers drive the pin. Pin inputs pass through a two-flop synchronizer. The synchronized values feed the data read-back and are also forwarded to the peripherals. The pad drivers and the peripherals themselves lie outside the block.

Top module: `pinmux_port`

## Requirements
- R1: After reset, the data register and the direction register both hold 0. With no peripheral enabled, every pin output enable is then 0.
- R2: A pin owned by GPIO drives its data register bit on `pin_out` and its direction register bit on `pin_oe`. Bits 1 and 0 are always owned by GPIO.
- R3: A read at address 0 returns, for each bit, the stored data bit when that bit's direction bit is 1, and otherwise the synchronized pin input. A read at address 1 returns the direction register.
- R4: A value on `pin_in` reaches the read-back path and the peripheral inputs after exactly two rising clock edges. The forwarded bits are: `spi_in` = synced bits 7..4, `iic_sda_in` = synced bit 7, `iic_scl_in` = synced bit 4, `can_rx_in` = synced bit 2.
- R5: Bit 7 is owned by the first enabled function in the order SPI, IIC (data), PWM channel 3, GPIO.
- R6: Bit 4 is owned by the first enabled function in the order SPI, IIC (clock), PWM channel 0, GPIO.
- R7: Bit 6 is owned by the first enabled function in the order SPI, PWM channel 2, GPIO. Bit 5 is owned by the first enabled function in the order SPI, PWM channel 1, GPIO.
- R8: When SPI owns bit 4+k, the pin takes `spi_out[k]` and `spi_oe[k]`. The mapping is k=0 MISO, 1 MOSI, 2 clock, 3 slave select.
- R9: When IIC owns a pin, the pin is open-drain. `pin_out` is 0, and `pin_oe` is 1 exactly when the IIC output for that line is 0.
- R10: When PWM channel k owns bit 4+k, the pin takes `pwm_out[k]` with the output enable at 1.
- R11: While `can_en` is 1, bit 3 drives `can_tx_o` with the output enable at 1, and bit 2 is held as an input (output enable 0, output 0).
- R12: A data register write is stored even while a peripheral owns the pin. The stored value appears on the pin as soon as GPIO regains ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 data, 1 direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| spi_en | input | 1 | SPI enabled |
| spi_out | input | 4 | SPI output values (MISO, MOSI, clock, select) |
| spi_oe | input | 4 | SPI output enables |
| iic_en | input | 1 | IIC enabled |
| iic_sda_o | input | 1 | IIC data line output (0 pulls low) |
| iic_scl_o | input | 1 | IIC clock line output (0 pulls low) |
| pwm_en | input | 4 | Per-channel PWM enable |
| pwm_out | input | 4 | PWM channel outputs |
| can_en | input | 1 | CAN enabled |
| can_tx_o | input | 1 | CAN transmit output |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| spi_in | output | 4 | Synchronized pin bits 7..4 to the SPI |
| iic_sda_in | output | 1 | Synchronized bit 7 to the IIC |
| iic_scl_in | output | 1 | Synchronized bit 4 to the IIC |
| can_rx_in | output | 1 | Synchronized bit 2 to the CAN receiver |

## Verification
A wrong owner choice on a pin appears on `pin_out` or `pin_oe` in the same cycle that the enables change. The bench therefore compares every pin against an independently written priority model on every clock. A corrupted data or direction bit can hide while a peripheral owns the pin. It surfaces on the first cycle GPIO regains ownership, and at once in the address-0 read-back through the direction-dependent select. A synchronizer of the wrong depth shifts every read-back and forwarded input by a cycle, so it fails the first comparison after any input change.

// File: rtl/pmx_pkg.sv
`timescale 1ns/1ps
package pmx_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ALT_W  = 4;

  typedef enum logic [2:0] {OWN_GPIO, OWN_PWM, OWN_IIC, OWN_SPI, OWN_CAN} owner_t;

  // Fixed per-pin priority chain; only enabled functions compete.
  function automatic owner_t pick_owner(input int unsigned idx, input logic spi_en,
                                        input logic iic_en, input logic [3:0] pwm_en,
                                        input logic can_en);
    owner_t o;
    logic [1:0] ch;
    o  = OWN_GPIO;
    ch = idx[1:0];
    case (idx)
      7, 4: begin
        if (spi_en)          o = OWN_SPI;
        else if (iic_en)     o = OWN_IIC;
        else if (pwm_en[ch]) o = OWN_PWM;
      end
      6, 5: begin
        if (spi_en)          o = OWN_SPI;
        else if (pwm_en[ch]) o = OWN_PWM;
      end
      3, 2: if (can_en) o = OWN_CAN;
      default: o = OWN_GPIO;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/pmx_sync.sv
`timescale 1ns/1ps
module pmx_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pmx_regs.sv
`timescale 1ns/1ps
module pmx_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rdata
);
  logic wr_data, wr_dir;
  assign wr_data = we && !addr;
  assign wr_dir  = we &&  addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
    end
  end

  // Outputs read back the latch, inputs read back the synchronized pad.
  logic [W-1:0] port_view;
  assign port_view = (dir_q & data_q) | (~dir_q & pin_sync);
  assign rdata     = addr ? dir_q : port_view;

  // R12
  data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> data_q == $past(wdata));

  // R3
  dir_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata));
endmodule

// File: rtl/pmx_select.sv
`timescale 1ns/1ps
module pmx_select
  import pmx_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] dir_q,
  input  logic         spi_en,
  input  logic [3:0]   spi_out,
  input  logic [3:0]   spi_oe,
  input  logic         iic_en,
  input  logic         iic_sda_o,
  input  logic         iic_scl_o,
  input  logic [3:0]   pwm_en,
  input  logic [3:0]   pwm_out,
  input  logic         can_en,
  input  logic         can_tx_o,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  // Per-pin views of each peripheral, zero where it has no connection.
  logic [W-1:0] spi_o_v, spi_e_v, iic_v, pwm_v, can_o_v, can_e_v;
  assign spi_o_v = {spi_out, 4'b0000};
  assign spi_e_v = {spi_oe,  4'b0000};
  assign iic_v   = {iic_sda_o, 2'b00, iic_scl_o, 4'b0000};
  assign pwm_v   = {pwm_out, 4'b0000};
  assign can_o_v = {4'b0000, can_tx_o, 3'b000};
  assign can_e_v = 8'b0000_1000;

  owner_t own [W];

  generate
    for (genvar g = 0; g < W; g++) begin : g_pin
      assign own[g] = pick_owner(g, spi_en, iic_en, pwm_en, can_en);
      always_comb begin
        case (own[g])
          OWN_SPI: begin pin_out[g] = spi_o_v[g]; pin_oe[g] = spi_e_v[g]; end
          OWN_IIC: begin pin_out[g] = 1'b0;       pin_oe[g] = ~iic_v[g];  end
          OWN_PWM: begin pin_out[g] = pwm_v[g];   pin_oe[g] = 1'b1;       end
          OWN_CAN: begin pin_out[g] = can_o_v[g]; pin_oe[g] = can_e_v[g]; end
          default: begin pin_out[g] = data_q[g];  pin_oe[g] = dir_q[g];   end
        endcase
      end
    end
  endgenerate

  // R5
  ss_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en |-> (pin_oe[7] == spi_oe[3]) && (pin_out[7] == spi_out[3]));

  // R9
  iic_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own[4] == OWN_IIC) |-> !pin_out[4] && (pin_oe[4] == !iic_scl_o));

  // R10
  pwm_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_en && !iic_en && pwm_en[3]) |-> pin_oe[7] && (pin_out[7] == pwm_out[3]));

  // R11
  can_rx_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    can_en |-> !pin_oe[2] && pin_oe[3]);
endmodule

// File: rtl/pinmux_port.sv
`timescale 1ns/1ps
module pinmux_port
  import pmx_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic         bus_addr,
  input  logic [7:0]   bus_wdata,
  output logic [7:0]   bus_rdata,
  input  logic         spi_en,
  input  logic [3:0]   spi_out,
  input  logic [3:0]   spi_oe,
  input  logic         iic_en,
  input  logic         iic_sda_o,
  input  logic         iic_scl_o,
  input  logic [3:0]   pwm_en,
  input  logic [3:0]   pwm_out,
  input  logic         can_en,
  input  logic         can_tx_o,
  input  logic [7:0]   pin_in,
  output logic [7:0]   pin_out,
  output logic [7:0]   pin_oe,
  output logic [3:0]   spi_in,
  output logic         iic_sda_in,
  output logic         iic_scl_in,
  output logic         can_rx_in
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [PORT_W-1:0] pin_sync, data_q, dir_q;

  pmx_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  pmx_regs #(.W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .pin_sync(pin_sync), .data_q(data_q), .dir_q(dir_q), .rdata(bus_rdata)
  );

  pmx_select #(.W(PORT_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .data_q(data_q), .dir_q(dir_q),
    .spi_en(spi_en), .spi_out(spi_out), .spi_oe(spi_oe),
    .iic_en(iic_en), .iic_sda_o(iic_sda_o), .iic_scl_o(iic_scl_o),
    .pwm_en(pwm_en), .pwm_out(pwm_out), .can_en(can_en), .can_tx_o(can_tx_o),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign spi_in     = pin_sync[7:4];
  assign iic_sda_in = pin_sync[7];
  assign iic_scl_in = pin_sync[4];
  assign can_rx_in  = pin_sync[2];

  // Edges seen since reset, saturating; gates the latency check.
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R4
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2) |-> (pin_sync == $past(pin_in, 2)));

  // R1
  reset_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd0) |-> (dir_q == '0) && (data_q == '0));
endmodule

// File: tb/pinmux_port_test.sv
`timescale 1ns/1ps
module pinmux_port_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0, pin_in = '0;
  logic spi_en = 0, iic_en = 0, iic_sda_o = 1, iic_scl_o = 1, can_en = 0, can_tx_o = 0;
  logic [3:0] spi_out = '0, spi_oe = '0, pwm_en = '0, pwm_out = '0;
  logic [7:0] bus_rdata, pin_out, pin_oe;
  logic [3:0] spi_in;
  logic iic_sda_in, iic_scl_in, can_rx_in;

  pinmux_port uut (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] m_data = '0, m_dir = '0;
  logic [7:0] syncq [$] = '{8'h00, 8'h00};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Candidate list per pin, highest priority first; codes 0 gpio 1 spi 2 iic 3 pwm 4 can.
  function automatic int owner_of(input int i);
    int cand [$];
    if (i >= 4) cand.push_back(1);
    if (i == 7 || i == 4) cand.push_back(2);
    if (i >= 4) cand.push_back(3);
    if (i == 3 || i == 2) cand.push_back(4);
    foreach (cand[k]) begin
      if (cand[k] == 1 && spi_en) return 1;
      if (cand[k] == 2 && iic_en) return 2;
      if (cand[k] == 3 && pwm_en[i-4]) return 3;
      if (cand[k] == 4 && can_en) return 4;
    end
    return 0;
  endfunction

  function automatic string pin_tag(input int i);
    if (i == 7) return "R5";
    if (i == 4) return "R6";
    if (i == 6 || i == 5) return "R7";
    if (i == 3 || i == 2) return "R11";
    return "R2";
  endfunction

  task automatic compare_all();
    logic [7:0] s = syncq[1];
    for (int i = 0; i < 8; i++) begin
      int o = owner_of(i);
      logic eo, ee;
      string t;
      case (o)
        1: begin eo = spi_out[i-4]; ee = spi_oe[i-4]; t = "R8"; end
        2: begin eo = 1'b0; ee = (i == 7) ? !iic_sda_o : !iic_scl_o; t = "R9"; end
        3: begin eo = pwm_out[i-4]; ee = 1'b1; t = "R10"; end
        4: begin eo = (i == 3) ? can_tx_o : 1'b0; ee = (i == 3); t = "R11"; end
        default: begin eo = m_data[i]; ee = m_dir[i]; t = "R2"; end
      endcase
      chk({pin_tag(i), "/", t, " pin"}, {pin_oe[i], pin_out[i]}, {ee, eo});
    end
    if (bus_addr) chk("R3 dir read", bus_rdata, m_dir);
    else begin
      logic [7:0] e = 0;
      for (int i = 0; i < 8; i++) e[i] = m_dir[i] ? m_data[i] : s[i];
      chk("R3 data read", bus_rdata, e);
    end
    chk("R4 forward", {spi_in, iic_sda_in, iic_scl_in, can_rx_in, 1'b0},
        {s[7:4], s[7], s[4], s[2], 1'b0});
  endtask

  task automatic model_next();
    if (!rst_n) begin
      m_data = '0; m_dir = '0; syncq = '{8'h00, 8'h00};
    end else begin
      if (bus_we) begin
        if (bus_addr) m_dir = bus_wdata; else m_data = bus_wdata;
      end
      syncq.push_front(pin_in);
      void'(syncq.pop_back());
    end
  endtask

  task automatic tick();
    model_next();
    @(negedge clk);
    compare_all();
  endtask

  task automatic randomize_inputs();
    bus_we    = ($urandom % 3) == 0;
    bus_addr  = $urandom % 2;
    bus_wdata = 8'($urandom);
    pin_in    = 8'($urandom);
    spi_en    = ($urandom % 4) == 0;
    iic_en    = ($urandom % 3) == 0;
    pwm_en    = 4'($urandom);
    can_en    = ($urandom % 2) == 0;
    spi_out   = 4'($urandom); spi_oe = 4'($urandom);
    pwm_out   = 4'($urandom);
    iic_sda_o = $urandom % 2; iic_scl_o = $urandom % 2;
    can_tx_o  = $urandom % 2;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state seen at the ports
    bus_addr = 1'b1;
    tick();
    chk("R1 dir after reset", bus_rdata, 8'h00);
    chk("R1 oe after reset", pin_oe, 8'h00);
    // R12: writes land while SPI owns the upper pins
    spi_en = 1'b1; spi_oe = 4'hF; spi_out = 4'h0;
    bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = 8'hFF; tick();
    bus_addr = 1'b0; bus_wdata = 8'hA5; tick();
    chk("R12 spi still owns", pin_out[7:4], 8'h0);
    bus_we = 1'b0; spi_en = 1'b0; tick();
    chk("R12 stored value on pins", pin_out, 8'hA5);
    // R4: single input change reaches read-back after two edges
    bus_addr = 1'b0; bus_we = 1'b1; bus_wdata = 8'h00; tick();
    bus_we = 1'b0; pin_in = 8'h00; bus_addr = 1'b1; bus_wdata = 8'h00; bus_we = 1'b1; tick();
    bus_we = 1'b0; bus_addr = 1'b0; tick(); tick();
    pin_in = 8'h3C; tick();
    chk("R4 one edge", bus_rdata, 8'h00);
    tick();
    chk("R4 two edges", bus_rdata, 8'h3C);
    for (int c = 0; c < 4000; c++) begin
      randomize_inputs();
      tick();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule